// File: doc/BRIEF.md
# Watchdog Timer with Lock-on-First-Write Setup

This block is a supervision counter that must be kicked regularly by software. If the kick stops arriving, the counter reaches its selected limit. The block then issues a single-cycle reset request and records the event in a flag that survives ordinary resets.

The counter runs from one of two count sources: every bus clock cycle, or a slow tick enable that pulses at about 1 kHz. Two setup registers choose the source and the limit. Each register accepts only the first write after a reset and ignores every later write, so a program that has lost control cannot loosen the protection. Software kicks the counter by writing a two-byte key sequence to a third address.

When the chip enters stop or debug mode, the counter reacts according to its source. With the bus clock as source it freezes and later resumes from the same value. With the slow tick as source it is cleared and later restarts from zero.

Top module: `cop_watchdog`

## Requirements
- R1: While `rst_n` or `por_n` is low at a clock edge, the counter is cleared and `wdog_rst` and the armed key state are cleared. Both resets are synchronous.
- R2: With neither setup register written since reset, the block uses limit code 2'b11 and the slow tick source. It therefore requests a reset after 2^10 ticks.
- R3: A write to address 0 sets the limit code from data bits [1:0]. A write to address 1 sets the source from data bit 0, where 1 selects the slow tick and 0 the bus clock. Only the first write to each address after a reset takes effect, and later writes change nothing until the next reset.
- R4: Writing 0x55 to address 2 arms the kick. A following write of 0xAA to address 2 clears the counter. Any other value written to address 2 disarms the kick without touching the counter, and 0xAA written while not armed has no effect.
- R5: With the bus clock as source, the counter holds its value while `stop_mode` or `debug_mode` is high, and resumes from that value afterwards.
- R6: With the slow tick as source, the counter is held at zero while `stop_mode` or `debug_mode` is high, and restarts from zero afterwards.
- R7: Limit code 2'b00 disables the watchdog: the counter stays at zero and `wdog_rst` never rises.
- R8: `timeout_flag` is set together with every reset request and stays set through `rst_n`. Only `por_n` clears it.
- R9: When the Nth counted event (tick or cycle) reaches the limit, `wdog_rst` is high for exactly one cycle, in the cycle after that event's clock edge. The counter then restarts from zero.
- R10: The limits are 2^5, 2^8 and 2^10 ticks for codes 01, 10 and 11 with the slow source. They are 2^13, 2^16 and 2^18 cycles for the same codes with the bus clock source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset, also clears the flag |
| tick_1k | input | 1 | Slow tick enable, one cycle high per tick |
| stop_mode | input | 1 | Chip is in stop mode |
| debug_mode | input | 1 | Chip is in debug mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| wdog_rst | output | 1 | One-cycle reset request on timeout |
| timeout_flag | output | 1 | Sticky timeout indicator |

## Verification
The bench attacks the lock by writing a shorter limit and then a different source and a longer limit. A design that accepted the second writes would time out at the wrong moment. It breaks the key sequence with a stray value and with an unarmed 0xAA. A design that kicked on either would miss the timeout that must follow. It halts the counter in both source modes. Swapping freeze and clear shifts the timeout by the length of the halt, or removes it. Finally, it resets the system after a timeout, where losing the flag on `rst_n` is reported, and it runs each limit code far enough that an off-by-one limit changes the cycle of the pulse.

// File: rtl/cop_pkg.sv
// Shared types and constants for the watchdog block.
// Assumes an 8-bit or wider write data bus.
package cop_pkg;
    typedef enum logic {
        SRC_BUS  = 1'b0,
        SRC_SLOW = 1'b1
    } src_e;

    typedef struct packed {
        logic [1:0] tsel;
        src_e       src;
    } cop_cfg_t;

    localparam logic [1:0] TSEL_OFF    = 2'b00;
    localparam cop_cfg_t   CFG_DEFAULT = '{tsel: 2'b11, src: SRC_SLOW};

    localparam int ADDR_TSEL = 0;
    localparam int ADDR_SRC  = 1;
    localparam int ADDR_KICK = 2;

    localparam logic [7:0] KEY_ARM  = 8'h55;
    localparam logic [7:0] KEY_FIRE = 8'hAA;
endpackage

// File: rtl/cop_cfg.sv
// Write-once setup registers: limit code and count source.
// Each field accepts the first write after reset; later writes are dropped.
// Assumes rst_n already combines system and power-on reset.
module cop_cfg
    import cop_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output cop_cfg_t      cfg
);
    logic tsel_lk;
    logic src_lk;
    logic hit_tsel;
    logic hit_src;

    // Decode the two setup addresses
    assign hit_tsel = wr_en && (wr_addr == AW'(ADDR_TSEL));
    assign hit_src  = wr_en && (wr_addr == AW'(ADDR_SRC));

    // Limit code register with its lock bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.tsel <= CFG_DEFAULT.tsel;
            tsel_lk  <= 1'b0;
        end else if (hit_tsel && !tsel_lk) begin
            cfg.tsel <= wr_data[1:0];
            tsel_lk  <= 1'b1;
        end
    end

    // Source select register with its lock bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.src <= CFG_DEFAULT.src;
            src_lk  <= 1'b0;
        end else if (hit_src && !src_lk) begin
            cfg.src <= src_e'(wr_data[0]);
            src_lk  <= 1'b1;
        end
    end

    // R3
    tsel_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsel_lk |=> $stable(cfg.tsel));
    // R3
    src_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_lk |=> $stable(cfg.src));
endmodule

// File: rtl/cop_kick.sv
// Two-write key detector for servicing the watchdog.
// Arms on the first key and fires on the second one only while armed.
// Assumes rst_n already combines system and power-on reset.
module cop_kick
    import cop_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          kick
);
    logic armed;
    logic hit;

    // Decode the service address
    assign hit  = wr_en && (wr_addr == AW'(ADDR_KICK));
    // Second key while armed completes the service
    assign kick = hit && armed && (wr_data == DW'(KEY_FIRE));

    // Arm state: only the first key arms, any write here otherwise disarms
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (hit)
            armed <= (wr_data == DW'(KEY_ARM));
    end

    // R4
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data == DW'(KEY_ARM)) |=> armed);
    // R4
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data != DW'(KEY_ARM)) |=> !armed);
endmodule

// File: rtl/cop_count.sv
// Timeout counter, reset request pulse and sticky timeout flag.
// Bus source freezes on halt, slow source clears on halt.
// Assumes rst_n combines both resets; por_n alone clears the flag.
module cop_count
    import cop_pkg::*;
#(
    parameter int SLOW_E1 = 5,
    parameter int SLOW_E2 = 8,
    parameter int SLOW_E3 = 10,
    parameter int BUS_E1  = 13,
    parameter int BUS_E2  = 16,
    parameter int BUS_E3  = 18
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     por_n,
    input  logic     tick,
    input  logic     halt,
    input  logic     kick,
    input  cop_cfg_t cfg,
    output logic     wdog_rst,
    output logic     timeout_flag
);
    localparam int CW = BUS_E3 + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic          on;
    logic          step;
    logic          wrap;

    // Last count value before the limit for a given setup
    function automatic logic [CW-1:0] last_val(cop_cfg_t c);
        int            e;
        logic [CW-1:0] one;
        one = CW'(1);
        case (c.tsel)
            2'b01:   e = (c.src == SRC_SLOW) ? SLOW_E1 : BUS_E1;
            2'b10:   e = (c.src == SRC_SLOW) ? SLOW_E2 : BUS_E2;
            default: e = (c.src == SRC_SLOW) ? SLOW_E3 : BUS_E3;
        endcase
        return (one << e) - one;
    endfunction

    // Counting qualifiers
    assign last = last_val(cfg);
    assign on   = (cfg.tsel != TSEL_OFF);
    assign step = !halt && ((cfg.src == SRC_BUS) || tick);
    assign wrap = on && !kick && step && (cnt == last);

    // Counter and one-cycle request pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            wdog_rst <= 1'b0;
        end else begin
            wdog_rst <= wrap;
            if (!on || kick || wrap || (halt && cfg.src == SRC_SLOW))
                cnt <= '0;
            else if (step)
                cnt <= cnt + 1'b1;
        end
    end

    // Sticky flag, cleared only at power-on reset
    always_ff @(posedge clk) begin
        if (!por_n)
            timeout_flag <= 1'b0;
        else if (rst_n && wrap)
            timeout_flag <= 1'b1;
    end

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);
    // R7
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.tsel == TSEL_OFF) |=> (cnt == '0 && !wdog_rst));
    // R5
    bus_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_BUS && halt && !kick) |=> $stable(cnt));
    // R6
    slow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_SLOW && halt) |=> (cnt == '0));
    // R4
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0 && !wdog_rst));
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        timeout_flag |=> timeout_flag);
    // R8
    flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        wdog_rst |-> timeout_flag);
endmodule

// File: rtl/cop_watchdog.sv
// Top of the watchdog: setup registers, key detector and counter.
// Inputs are synchronous to clk; tick_1k is a one-cycle enable.
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int AW      = 2,
    parameter int DW      = 8,
    parameter int SLOW_E1 = 5,
    parameter int SLOW_E2 = 8,
    parameter int SLOW_E3 = 10,
    parameter int BUS_E1  = 13,
    parameter int BUS_E2  = 16,
    parameter int BUS_E3  = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          tick_1k,
    input  logic          stop_mode,
    input  logic          debug_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wdog_rst,
    output logic          timeout_flag
);
    logic     any_rst_n;
    cop_cfg_t cfg;
    logic     kick;
    logic     halt;

    // Either reset clears the working state
    assign any_rst_n = rst_n & por_n;
    // Stop and debug are treated alike
    assign halt      = stop_mode | debug_mode;

    cop_cfg #(.AW(AW), .DW(DW)) u_cfg (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    cop_kick #(.AW(AW), .DW(DW)) u_kick (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .kick    (kick)
    );

    cop_count #(
        .SLOW_E1 (SLOW_E1), .SLOW_E2 (SLOW_E2), .SLOW_E3 (SLOW_E3),
        .BUS_E1  (BUS_E1),  .BUS_E2  (BUS_E2),  .BUS_E3  (BUS_E3)
    ) u_count (
        .clk          (clk),
        .rst_n        (any_rst_n),
        .por_n        (por_n),
        .tick         (tick_1k),
        .halt         (halt),
        .kick         (kick),
        .cfg          (cfg),
        .wdog_rst     (wdog_rst),
        .timeout_flag (timeout_flag)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !any_rst_n |=> !wdog_rst);
endmodule

// File: tb/cop_watchdog_test.sv
`timescale 1ns/1ps
module cop_watchdog_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, por_n = 1'b0;
    logic       tick_1k = 1'b0, stop_mode = 1'b0, debug_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wdog_rst, timeout_flag;

    always #2.5 clk = ~clk;

    cop_watchdog uut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_1k(tick_1k),
        .stop_mode(stop_mode), .debug_mode(debug_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .wdog_rst(wdog_rst),
        .timeout_flag(timeout_flag)
    );

    int    checks = 0, errors = 0;
    string phase = "R1";
    int    tdiv = 0;
    bit    tick_on = 0;
    int    pulses = 0;
    bit    finished = 0;

    // reference model state
    int m_cnt = 0, m_tsel = 3, m_src = 1;
    bit m_lk0 = 0, m_lk1 = 0, m_arm = 0, m_pulse = 0, m_flag = 0;

    function automatic int limit_of(int tsel, int src);
        int e;
        if (tsel == 1)      e = src ? 5 : 13;
        else if (tsel == 2) e = src ? 8 : 16;
        else                e = src ? 10 : 18;
        return 1 << e;
    endfunction

    always @(posedge clk) begin
        if (!por_n || !rst_n) begin
            m_cnt = 0; m_tsel = 3; m_src = 1; m_lk0 = 0; m_lk1 = 0;
            m_arm = 0; m_pulse = 0;
            if (!por_n) m_flag = 0;
        end else begin
            bit fire, pl;
            fire = wr_en && wr_addr == 2 && wr_data == 8'hAA && m_arm;
            pl = 0;
            if (m_tsel == 0) m_cnt = 0;
            else if (fire) m_cnt = 0;
            else if (stop_mode || debug_mode) begin
                if (m_src == 1) m_cnt = 0;
            end else if (m_src == 0 || tick_1k) begin
                m_cnt++;
                if (m_cnt == limit_of(m_tsel, m_src)) begin
                    m_cnt = 0; pl = 1;
                end
            end
            m_pulse = pl;
            if (pl) m_flag = 1;
            if (wr_en && wr_addr == 2) m_arm = (wr_data == 8'h55);
            if (wr_en && wr_addr == 0 && !m_lk0) begin m_tsel = wr_data[1:0]; m_lk0 = 1; end
            if (wr_en && wr_addr == 1 && !m_lk1) begin m_src = wr_data[0]; m_lk1 = 1; end
        end
    end

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // advance n cycles, comparing against the model at each falling edge
    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(wdog_rst == m_pulse, phase, "wdog_rst", wdog_rst, m_pulse);
            chk(timeout_flag == m_flag, phase, "timeout_flag", timeout_flag, m_flag);
            if (wdog_rst) pulses++;
            tdiv = (tdiv + 1) % 4;
            tick_1k = tick_on && (tdiv == 0);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic sys_reset();
        rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        phase = "R1";
        cyc(3);
        por_n = 1'b1; rst_n = 1'b1;
        cyc(2);
        chk(wdog_rst == 0 && timeout_flag == 0, "R1", "outputs after reset", wdog_rst + timeout_flag, 0);

        // R2 default setup: slow, 2^10 ticks (R10)
        phase = "R2"; tick_on = 1; pulses = 0;
        cyc(4200);
        chk(pulses == 1, "R2", "pulses with default setup", pulses, 1);

        // R8 flag survives rst_n, cleared by por_n
        phase = "R8";
        sys_reset(); cyc(1);
        chk(timeout_flag == 1, "R8", "flag after rst_n", timeout_flag, 1);
        por_n = 1'b0; cyc(2); por_n = 1'b1; cyc(1);
        chk(timeout_flag == 0, "R8", "flag after por_n", timeout_flag, 0);

        // R3 lock: first writes win, later ones ignored
        phase = "R3"; pulses = 0;
        wr(0, 1); wr(1, 1); wr(0, 3); wr(1, 0);
        cyc(200);
        chk(pulses == 1, "R3", "pulses after locked setup", pulses, 1);

        // R4 regular kicks keep the counter away from the limit
        phase = "R4";
        wr(2, 8'h55); wr(2, 8'hAA); pulses = 0;
        for (int k = 0; k < 5; k++) begin
            cyc(80); wr(2, 8'h55); wr(2, 8'hAA);
        end
        chk(pulses == 0, "R4", "pulses with kicks", pulses, 0);
        // broken sequence and unarmed fire must not kick
        cyc(60); wr(2, 8'h55); wr(2, 8'h12); wr(2, 8'hAA); cyc(80);
        chk(pulses == 1, "R4", "pulses with broken key", pulses, 1);

        // R6 slow source cleared on halt
        phase = "R6";
        wr(2, 8'h55); wr(2, 8'hAA); pulses = 0;
        cyc(100); stop_mode = 1; cyc(50); stop_mode = 0; cyc(100);
        cyc(10); debug_mode = 1; cyc(40); debug_mode = 0; cyc(100);
        chk(pulses == 0, "R6", "pulses across halts", pulses, 0);

        // R5 bus source frozen on halt, 2^13 cycles (R10)
        phase = "R5";
        sys_reset(); wr(0, 1); wr(1, 0); pulses = 0;
        cyc(5000); stop_mode = 1; cyc(300); stop_mode = 0;
        debug_mode = 1; cyc(20); debug_mode = 0; cyc(3000);
        chk(pulses == 0, "R5", "pulses before frozen limit", pulses, 0);
        cyc(400);
        chk(pulses == 1, "R5", "pulses after resume", pulses, 1);

        // R7 disabled code
        phase = "R7";
        sys_reset(); wr(0, 0); wr(1, 0); pulses = 0;
        cyc(3000);
        chk(pulses == 0, "R7", "pulses when disabled", pulses, 0);

        // R9 periodic single-cycle pulses, slow 2^8 ticks
        phase = "R9";
        sys_reset(); wr(0, 2); pulses = 0;
        cyc(2100);
        chk(pulses == 2, "R9", "high cycles over two periods", pulses, 2);

        // R10 bus 2^16 cycles
        phase = "R10";
        sys_reset(); wr(0, 2); wr(1, 0); pulses = 0;
        cyc(65600);
        chk(pulses == 1, "R10", "pulses at bus code 10", pulses, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule